// File: doc/BRIEF.md
# Parallel Flash Command Interface and Status Register

This block is the bus-facing control logic of a parallel NOR flash with a 16-bit data bus. A host writes one-byte commands by pulsing the write enable while the chip enable is low. Those commands choose what later bus reads return: words from the memory array, the two identifier words, or an 8-bit status byte. The array contents and the program/erase engine are outside the block; the array word arrives on an input port, and the engine reports through a ready level and per-bit set and clear pulses.

The status byte gives one ready flag and several result flags. Some result flags are sticky. The engine can raise them but cannot lower them. Only the clear command lowers them, so a host can run a series of program or erase steps and then look at the combined result once. A status read takes a snapshot when the read starts. The value stays fixed for as long as chip enable and output enable both stay low, even if the live status changes in that time.

All bus strobes are sampled on the system clock, and an edge counts as one clock sample that differs from the one before.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the block is in array-read mode. The status byte is 80h: ready is set and every result flag is clear.
- R2: Command 90h selects identifier mode. In that mode a read with every address bit above bit 0 at zero returns MFR_CODE when bit 0 is 0 and DEV_CODE when bit 0 is 1. Any other address returns 0000h.
- R3: Command FFh selects array-read mode, where a read returns the `arr_data` word.
- R4: Command 70h selects status mode. Every read then returns {8'h00, status} until another mode command arrives. Status bit 0 always reads 0.
- R5: A status read shows the status captured in its first clock sample. The value holds while `ce_n` and `oe_n` stay low, and a fresh capture happens only after one of them goes high and back low.
- R6: Status bit 7 follows `wsm_ready` with one clock of latency.
- R7: A `wsm_set` pulse sets status bits 1 to 6 (`wsm_set[k]` sets bit k). Bits 1, 3, 4 and 5 then stay set, whatever `wsm_clr` does.
- R8: `wsm_clr[0]` clears status bit 2 and `wsm_clr[1]` clears status bit 6. If a set and a clear of the same bit arrive together, the set wins.
- R9: Command 50h clears status bits 1, 3, 4 and 5. It leaves bits 2 and 6 and the read mode unchanged.
- R10: A command is taken at a rising edge of `we_n` only while `ce_n` is low. A byte other than FFh, 90h, 70h or 50h leaves the read mode unchanged.
- R11: `dq_oe` is 1 and `dq_out` carries data only while both `ce_n` and `oe_n` are low. At all other times `dq_oe` is 0 and `dq_out` is 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a command is taken on its rising edge |
| addr | input | ADDR_W | Word address |
| cmd_byte | input | 8 | Command byte on the low data lines |
| arr_data | input | 16 | Word from the memory array at `addr` |
| wsm_ready | input | 1 | Program/erase engine idle |
| wsm_set | input | 6 | Set pulses for status bits 6..1 |
| wsm_clr | input | 2 | Clear pulses for status bit 2 ([0]) and bit 6 ([1]) |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Read data drive enable |

## Verification
Random sequences mix mode commands, unknown bytes, engine set/clear pulses and reads. Read addresses are either confined to bit 0 or fully random. This separates the manufacturer and device words from the all-zero result for an out-of-range identifier address. Engine pulses with random masks are interleaved with clear commands. They show whether the sticky bits and the engine-clearable bits follow different clear rules. Directed cases change the status in the middle of a read to catch a snapshot that tracks the live value. They also write a command with chip enable high and gate the output with only one enable low.

// File: rtl/flash_ci_pkg.sv
// Package: shared read-mode type, command codes and status bit classes
// for the flash command interface. Assumes an 8-bit status byte.
package flash_ci_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_IDENT  = 2'd1,
        RD_STATUS = 2'd2
    } rd_mode_e;

    localparam logic [7:0] CMD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLEAR  = 8'h50;

    localparam int unsigned ST_W      = 8;
    localparam int unsigned READY_BIT = 7;
    // bits only the clear command can lower
    localparam logic [7:0] STICKY_MASK = 8'b0011_1010;
    // bits the engine may lower
    localparam logic [7:0] ENGINE_CLR_MASK = 8'b0100_0100;
    localparam logic [7:0] STATUS_RESET = 8'h80;

endpackage

// File: rtl/flash_bus_edges.sv
// Module: flash_bus_edges
// Samples the asynchronous-style bus strobes on clk and derives a command
// strobe (write-enable rising edge while chip enable low) plus read-active
// and read-start indications. Assumes strobes are already synchronous to clk.
module flash_bus_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic cmd_strobe,
    output logic read_active,
    output logic read_start
);

    logic we_prev_q;
    logic rd_prev_q;

    // read is active while both enables are low
    assign read_active = ~ce_n & ~oe_n;
    // first sample of a read: either enable has just fallen
    assign read_start  = read_active & ~rd_prev_q;
    // command accepted on write-enable rise with chip selected
    assign cmd_strobe  = we_n & ~we_prev_q & ~ce_n;

    // remember last-sample strobe levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_prev_q <= 1'b1;
            rd_prev_q <= 1'b0;
        end else begin
            we_prev_q <= we_n;
            rd_prev_q <= read_active;
        end
    end

endmodule

// File: rtl/flash_cmd_decode.sv
// Module: flash_cmd_decode
// Decodes command bytes into the persistent read mode and a one-cycle
// sticky-clear pulse. Assumes cmd_strobe lasts a single clock.
module flash_cmd_decode
    import flash_ci_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_strobe,
    input  logic [7:0] cmd_byte,
    output rd_mode_e mode,
    output logic     clr_sticky
);

    rd_mode_e mode_q;
    rd_mode_e mode_d;

    // next mode: only the three mode commands change it
    always_comb begin
        mode_d = mode_q;
        if (cmd_strobe) begin
            unique case (cmd_byte)
                CMD_ARRAY:  mode_d = RD_ARRAY;
                CMD_IDENT:  mode_d = RD_IDENT;
                CMD_STATUS: mode_d = RD_STATUS;
                default:    mode_d = mode_q;
            endcase
        end
    end

    // hold the read mode across bus cycles
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= RD_ARRAY;
        else        mode_q <= mode_d;
    end

    assign mode       = mode_q;
    assign clr_sticky = cmd_strobe && (cmd_byte == CMD_CLEAR);

endmodule

// File: rtl/flash_status_reg.sv
// Module: flash_status_reg
// Holds the status byte: bit 7 tracks engine ready, sticky error bits
// cleared only by command, engine-clearable bits, bit 0 fixed at zero.
// Also provides the read snapshot taken at the first sample of a read.
module flash_status_reg
    import flash_ci_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wsm_ready,
    input  logic [6:1]      wsm_set,
    input  logic [1:0]      wsm_clr,
    input  logic            clr_sticky,
    input  logic            read_start,
    output logic [ST_W-1:0] status_live,
    output logic [ST_W-1:0] status_view
);

    logic [ST_W-1:0] snap_q;

    for (genvar b = 0; b < ST_W; b++) begin : g_bit
        if (b == 0) begin : g_rsvd
            assign status_live[b] = 1'b0;
        end else if (b == READY_BIT) begin : g_ready
            logic q;
            // ready flag follows the engine level
            always_ff @(posedge clk) begin
                if (!rst_n) q <= STATUS_RESET[b];
                else        q <= wsm_ready;
            end
            assign status_live[b] = q;
        end else if (STICKY_MASK[b]) begin : g_sticky
            logic q;
            // error flag: engine sets, only the clear command lowers
            always_ff @(posedge clk) begin
                if (!rst_n) q <= STATUS_RESET[b];
                else        q <= wsm_set[b] | (q & ~clr_sticky);
            end
            assign status_live[b] = q;
        end else begin : g_engine
            localparam int CI = (b == 2) ? 0 : 1;
            logic q;
            // result flag: engine sets and clears, set wins
            always_ff @(posedge clk) begin
                if (!rst_n) q <= STATUS_RESET[b];
                else        q <= wsm_set[b] | (q & ~wsm_clr[CI]);
            end
            assign status_live[b] = q;
        end
    end

    // freeze the status seen by the bus at the start of each read
    always_ff @(posedge clk) begin
        if (!rst_n)          snap_q <= STATUS_RESET;
        else if (read_start) snap_q <= status_live;
    end

    assign status_view = read_start ? status_live : snap_q;

endmodule

// File: rtl/flash_read_mux.sv
// Module: flash_read_mux
// Selects the read word by mode and gates it with the read enables.
// Assumes identifier words are only valid with upper address bits zero.
module flash_read_mux
    import flash_ci_pkg::*;
#(
    parameter int unsigned ADDR_W   = 22,
    parameter logic [15:0] MFR_CODE = 16'h0089,
    parameter logic [15:0] DEV_CODE = 16'h88C4
) (
    input  rd_mode_e        mode,
    input  logic            read_active,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]     arr_data,
    input  logic [ST_W-1:0] status_view,
    output logic [15:0]     dq_out,
    output logic            dq_oe
);

    localparam int unsigned HI_W = ADDR_W - 1;

    logic        id_addr_ok;
    logic [15:0] word;

    assign id_addr_ok = (addr[ADDR_W-1:1] == {HI_W{1'b0}});

    // pick the word the current mode presents
    always_comb begin
        unique case (mode)
            RD_IDENT:  word = id_addr_ok ? (addr[0] ? DEV_CODE : MFR_CODE) : 16'h0000;
            RD_STATUS: word = {8'h00, status_view};
            default:   word = arr_data;
        endcase
    end

    assign dq_oe  = read_active;
    assign dq_out = read_active ? word : 16'h0000;

endmodule

// File: rtl/flash_cmd_if.sv
// Module: flash_cmd_if (top)
// Command interface of a 16-bit parallel NOR flash: command decode,
// read-mode selection and status register with read snapshot.
// Assumes all bus strobes are synchronous to clk; array and engine abstract.
module flash_cmd_if
    import flash_ci_pkg::*;
#(
    parameter int unsigned ADDR_W   = 22,
    parameter logic [15:0] MFR_CODE = 16'h0089,
    parameter logic [15:0] DEV_CODE = 16'h88C4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        cmd_byte,
    input  logic [15:0]       arr_data,
    input  logic              wsm_ready,
    input  logic [6:1]        wsm_set,
    input  logic [1:0]        wsm_clr,
    output logic [15:0]       dq_out,
    output logic              dq_oe
);

    logic            cmd_strobe;
    logic            read_active;
    logic            read_start;
    logic            clr_sticky;
    rd_mode_e        mode;
    logic [ST_W-1:0] status_live;
    logic [ST_W-1:0] status_view;

    flash_bus_edges u_edges (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .cmd_strobe(cmd_strobe), .read_active(read_active), .read_start(read_start)
    );

    flash_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .cmd_byte(cmd_byte),
        .mode(mode), .clr_sticky(clr_sticky)
    );

    flash_status_reg u_st (
        .clk(clk), .rst_n(rst_n), .wsm_ready(wsm_ready), .wsm_set(wsm_set),
        .wsm_clr(wsm_clr), .clr_sticky(clr_sticky), .read_start(read_start),
        .status_live(status_live), .status_view(status_view)
    );

    flash_read_mux #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_mux (
        .mode(mode), .read_active(read_active), .addr(addr), .arr_data(arr_data),
        .status_view(status_view), .dq_out(dq_out), .dq_oe(dq_oe)
    );

endmodule

// File: rtl/flash_cmd_if_chk.sv
// Module: flash_cmd_if_chk
// Property checker bound into flash_cmd_if; observes ports and internal
// mode, status and clear pulse.
module flash_cmd_if_chk
    import flash_ci_pkg::*;
#(
    parameter int unsigned ADDR_W   = 22,
    parameter logic [15:0] MFR_CODE = 16'h0089
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wsm_ready,
    input logic [6:1]        wsm_set,
    input logic [15:0]       dq_out,
    input logic              dq_oe,
    input rd_mode_e          mode,
    input logic [ST_W-1:0]   status,
    input logic              clr_sticky
);

    // R11
    out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (!dq_oe && dq_out == 16'h0000));

    // R4
    stat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && mode == RD_STATUS) |-> (dq_out[15:8] == 8'h00 && !dq_out[0]));

    // R5
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && mode == RD_STATUS && $past(!ce_n && !oe_n)
         && $past(mode) == RD_STATUS) |-> $stable(dq_out));

    // R6
    ready_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[READY_BIT] == $past(wsm_ready)));

    // R7
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_sticky) |-> ((($past(status) & STICKY_MASK) & ~status) == 8'h00));

    // R9
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sticky && ((wsm_set & STICKY_MASK[6:1]) == 6'h00))
        |=> ((status & STICKY_MASK) == 8'h00));

    // R2
    ident_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && mode == RD_IDENT && addr == {ADDR_W{1'b0}}) |-> (dq_out == MFR_CODE));

endmodule

bind flash_cmd_if flash_cmd_if_chk #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .addr(addr),
    .wsm_ready(wsm_ready), .wsm_set(wsm_set), .dq_out(dq_out), .dq_oe(dq_oe),
    .mode(mode), .status(status_live), .clr_sticky(clr_sticky)
);

// File: tb/tb_flash_cmd_if.sv
// Bench for flash_cmd_if: directed corner cases plus seeded random traffic
// checked against a behavioural model kept in bench variables.
module tb_flash_cmd_if;

    localparam int unsigned ADDR_W = 22;
    localparam logic [15:0] MFR = 16'h0089;
    localparam logic [15:0] DEV = 16'h88C4;
    localparam int unsigned M_ARRAY = 0, M_IDENT = 1, M_STATUS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] cmd_byte = 8'h00;
    logic [15:0] arr_data = 16'h0000;
    logic wsm_ready = 1'b1;
    logic [6:1] wsm_set = '0;
    logic [1:0] wsm_clr = '0;
    logic [15:0] dq_out;
    logic dq_oe;

    int n_tests = 0;
    int n_fail  = 0;
    int unsigned m_mode = M_ARRAY;
    logic [7:0] m_st = 8'h80;

    flash_cmd_if #(.ADDR_W(ADDR_W), .MFR_CODE(MFR), .DEV_CODE(DEV)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .cmd_byte(cmd_byte), .arr_data(arr_data),
        .wsm_ready(wsm_ready), .wsm_set(wsm_set), .wsm_clr(wsm_clr),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [ADDR_W-1:0] a, input logic [15:0] arr);
        case (m_mode)
            M_IDENT:  return (a[ADDR_W-1:1] == '0) ? (a[0] ? DEV : MFR) : 16'h0000;
            M_STATUS: return {8'h00, m_st};
            default:  return arr;
        endcase
    endfunction

    function automatic void model_cmd(input logic [7:0] b);
        case (b)
            8'hFF: m_mode = M_ARRAY;
            8'h90: m_mode = M_IDENT;
            8'h70: m_mode = M_STATUS;
            8'h50: m_st = m_st & 8'hC5;
            default: ;
        endcase
    endfunction

    task automatic write_cmd(input logic [7:0] b, input bit ce_low);
        @(negedge clk); ce_n = !ce_low; we_n = 1'b0; cmd_byte = b;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
        if (ce_low) model_cmd(b);
    endtask

    task automatic wsm_op(input logic rdy, input logic [6:1] s, input logic [1:0] c);
        @(negedge clk); wsm_ready = rdy; wsm_set = s; wsm_clr = c;
        @(negedge clk); wsm_set = '0; wsm_clr = '0;
        m_st[7] = rdy;
        if (c[0]) m_st[2] = 1'b0;
        if (c[1]) m_st[6] = 1'b0;
        m_st[6:1] = m_st[6:1] | s;
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input logic [15:0] arr, input string req);
        @(negedge clk); addr = a; arr_data = arr; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        chk(req, {dq_oe, dq_out}, {1'b1, exp_read(a, arr)});
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] s0;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state: array mode, then status 0080h
        do_read(22'h000123, 16'hBEEF, "R1 array after reset");
        write_cmd(8'h70, 1'b1);
        do_read('0, 16'h0000, "R1 status after reset");
        // R11 gating with a single enable low
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk); chk("R11 oe high", {dq_oe, dq_out}, 17'h0);
        ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk); chk("R11 ce high", {dq_oe, dq_out}, 17'h0);
        oe_n = 1'b1;
        // R2 identifier words and out-of-range address
        write_cmd(8'h90, 1'b1);
        do_read(22'h0, 16'h1111, "R2 mfr");
        do_read(22'h1, 16'h1111, "R2 dev");
        do_read(22'h2, 16'h1111, "R2 high bits");
        // R10 ignored command with chip enable high, unknown byte
        write_cmd(8'hFF, 1'b0);
        do_read(22'h1, 16'h2222, "R10 ce high ignored");
        write_cmd(8'h12, 1'b1);
        do_read(22'h0, 16'h2222, "R10 unknown byte");
        // R3 back to array
        write_cmd(8'hFF, 1'b1);
        do_read(22'h3, 16'hA5A5, "R3 array");
        // R7 R8 sticky vs engine-clearable, set wins
        write_cmd(8'h70, 1'b1);
        wsm_op(1'b0, 6'b11_1111, 2'b00);
        do_read('0, 16'h0, "R6 R7 all set busy");
        wsm_op(1'b1, 6'b00_0000, 2'b11);
        do_read('0, 16'h0, "R7 R8 engine clear");
        wsm_op(1'b1, 6'b00_0010, 2'b01);
        do_read('0, 16'h0, "R8 set wins");
        // R9 clear command keeps bit 2, keeps mode
        write_cmd(8'h50, 1'b1);
        do_read('0, 16'h0, "R9 clear sticky");
        // R5 snapshot holds during a read, refreshed after toggle
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); s0 = dq_out;
        chk("R5 first sample", {1'b0, s0}, {1'b0, 8'h00, m_st});
        wsm_set = 6'b01_0000;
        @(negedge clk); wsm_set = '0; m_st[5] = 1'b1;
        @(negedge clk); chk("R5 held", {1'b0, dq_out}, {1'b0, s0});
        oe_n = 1'b1;
        @(negedge clk); oe_n = 1'b0;
        @(negedge clk); chk("R5 refreshed", {1'b0, dq_out}, {1'b0, 8'h00, m_st});
        ce_n = 1'b1; oe_n = 1'b1;
        // random mix
        for (int i = 0; i < 300; i++) begin
            int unsigned op = $urandom_range(0, 3);
            if (op == 0) begin
                logic [7:0] cb;
                case ($urandom_range(0, 4))
                    0: cb = 8'hFF; 1: cb = 8'h90; 2: cb = 8'h70; 3: cb = 8'h50;
                    default: cb = 8'($urandom);
                endcase
                write_cmd(cb, ($urandom_range(0, 7) != 0));
            end else if (op == 1) begin
                wsm_op(1'($urandom), 6'($urandom), 2'($urandom));
            end else begin
                logic [ADDR_W-1:0] a;
                a = $urandom_range(0, 1) ? ADDR_W'($urandom_range(0, 1)) : ADDR_W'($urandom);
                do_read(a, 16'($urandom), "R2 R3 R4 R9 random read");
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule